// File: doc/BRIEF.md
# Supply Threshold Crossing Interrupt Controller

This block watches the digital output of an external supply comparator. That output is high while the supply is above a detection threshold and low while it is below. The level is brought into the bus-clock domain through a synchronizer. It is then sampled on a tick made by dividing the bus clock, and any difference between two successive samples counts as a crossing. A crossing in either direction sets a sticky detection flag. The interrupt request fires only when that flag goes from 0 to 1, so software must clear the flag before another request can occur.

The current power mode is an input to the block and changes how crossings are handled. In run mode, and in wait mode while peripheral clocks keep running, crossings in both directions can raise the interrupt. In stop mode, and in wait mode with peripheral clocks stopped, only an upward crossing counts, and only when the stop-wake enable is set. In stop mode that upward crossing bypasses the flag and also asserts the wake request. If stop mode is entered while the last sample shows the supply above the threshold, a request and a wake are raised at once.

Software reads and writes one 6-bit control word. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `supply_xing_irq`

## Requirements
- R1: After reset, the control word reads 0 (all enables off, sampling select 00, flag clear), and `irq_o` and `wake_o` are low.
- R2: Control word layout: bit 0 detector enable, bit 1 interrupt enable, bit 2 stop-wake enable, bits 4:3 sampling select, bit 5 detection flag. The select picks a sampling tick of the bus clock divided by 8, 16, 32 or 64 for codes 00, 01, 10, 11. Measured in negative clock edges from the drive, a level change on `cmp_async` reaches `irq_o` after no fewer than 4 and no more than the divisor plus 3.
- R3: While the detector is enabled, a sampled crossing in either direction sets the flag. A write with bit 5 = 0 clears it, and a write with bit 5 = 1 leaves it unchanged.
- R4: `irq_o` is a single-cycle pulse, and in run mode it fires only when the flag goes from 0 to 1. While the flag stays 1, further crossings raise no request.
- R5: A request needs both the detector enable and the interrupt enable. With the interrupt enable at 0, a crossing sets the flag but raises no request. With the detector enable at 0, the flag does not change and no request is raised.
- R6: In stop mode (`pwr_mode` = 2'b10) with the stop-wake enable set, an upward crossing pulses both `irq_o` and `wake_o` whatever the flag holds. A downward crossing raises neither.
- R7: In wait mode (`pwr_mode` = 2'b01) with `pclk_off` = 1, an upward crossing raises `irq_o` (not `wake_o`) if the flag was 0. A downward crossing raises nothing but still sets the flag. With `pclk_off` = 0, wait mode behaves as run mode (2'b00; code 2'b11 is also treated as run).
- R8: When `pwr_mode` changes to stop while the last sample is high and both the detector and interrupt enables are set, `irq_o` and `wake_o` pulse in the following cycle. If the last sample is low, entering stop raises nothing.
- R9: If a flag-clearing write lands in the same cycle as a new detection, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_async | input | 1 | Comparator level, asynchronous; 1 = supply above threshold |
| pwr_mode | input | 2 | 00 run, 01 wait, 10 stop, 11 treated as run |
| pclk_off | input | 1 | Peripheral clocks stopped (qualifies wait mode) |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 6 | Control word write data |
| reg_rdata | output | 6 | Control word read value, flag in bit 5 |
| irq_o | output | 1 | Interrupt request pulse |
| wake_o | output | 1 | Wake request pulse |

## Verification
Two events can fall in the same cycle: a software write that clears the flag, and a hardware detection that sets it. The bench first locks onto the sampling phase by waiting for one interrupt. It then changes the comparator level and times a clear-write so that it is captured on exactly the edge where the next detection sets the flag. It judges the outcome by reading the flag back through the control word, which must show 1, and it also confirms that no interrupt fires, because the flag never went through 0. Two further checks back this up. A clear-write with no detection pending must still empty the flag, and the sampling-window sweep fixes the exact edge that the collision test aims at.

// File: rtl/scm_pkg.sv
package scm_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_WAIT = 2'b01,
    PM_STOP = 2'b10,
    PM_RSVD = 2'b11
  } pmode_e;

  localparam int CTL_W  = 6;
  localparam int FLAG_B = 5;

  // Field order matches the control word bits [4:0].
  typedef struct packed {
    logic [1:0] sel;
    logic       swk;
    logic       ien;
    logic       det;
  } cfg_t;
endpackage

// File: rtl/scm_sync.sv
module scm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/scm_sampler.sv
module scm_sampler #(
  parameter int CNT_W      = 6,
  parameter int BASE_SHIFT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] sel,
  input  logic       lvl,
  output logic       rise_o,
  output logic       fall_o,
  output logic       level_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic [CNT_W:0]   span;
  logic [1:0]       sel_q;
  logic             samp_q;
  logic             rise_q;
  logic             fall_q;
  logic             tick;

  // Tick once every 2**(BASE_SHIFT+sel) bus cycles.
  always_comb begin
    span = (CNT_W+1)'(1) << (BASE_SHIFT + int'(sel));
    mask = span[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};
    tick = ((cnt & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sel_q  <= '0;
      samp_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sel_q <= sel;
      if (sel != sel_q) cnt <= '0;
      else              cnt <= cnt + 1'b1;
      // Disabled detector follows the level so enabling it reports no stale edge.
      if (!en || tick) samp_q <= lvl;
      rise_q <= en && tick &&  lvl && !samp_q;
      fall_q <= en && tick && !lvl &&  samp_q;
    end
  end

  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign level_o = samp_q;

  p_cross_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_q || fall_q) |-> $past(tick));
  p_one_direction_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_q, fall_q}));
endmodule

// File: rtl/scm_ctrl.sv
module scm_ctrl
  import scm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [CTL_W-1:0] reg_wdata,
  input  logic [1:0]       pwr_mode,
  input  logic             pclk_off,
  input  logic             rise,
  input  logic             fall,
  input  logic             samp_lvl,
  output cfg_t             cfg_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             wake_o
);
  cfg_t cfg_q;
  logic flag_q, irq_q, wake_q, stop_q;
  logic in_stop, in_wait_off, low_path, both_en, any_x;
  logic run_req, waitoff_req, stop_req, entry_req;
  logic set_flag, clr_flag, flag_d;

  always_comb begin
    in_stop     = (pwr_mode == PM_STOP);
    in_wait_off = (pwr_mode == PM_WAIT) && pclk_off;
    low_path    = in_stop || in_wait_off;
    both_en     = cfg_q.det && cfg_q.ien;
    any_x       = rise || fall;
    run_req     = both_en && !low_path && any_x && !flag_q;
    waitoff_req = both_en && in_wait_off && cfg_q.swk && rise && !flag_q;
    stop_req    = both_en && in_stop && cfg_q.swk && rise;
    entry_req   = both_en && in_stop && !stop_q && samp_lvl;
    set_flag    = cfg_q.det && any_x;
    clr_flag    = reg_wr && !reg_wdata[FLAG_B];
    if (set_flag)      flag_d = 1'b1;
    else if (clr_flag) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (reg_wr) cfg_q <= cfg_t'(reg_wdata[CTL_W-2:0]);
      flag_q <= flag_d;
      irq_q  <= run_req || waitoff_req || stop_req || entry_req;
      wake_q <= stop_req || entry_req;
      stop_q <= in_stop;
    end
  end

  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
  assign wake_o = wake_q;

  p_irq_needs_enables_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(cfg_q.det && cfg_q.ien));
  p_wake_with_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> irq_q);
  p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.det && (rise || fall)) |=> flag_q);
  p_wake_only_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> $past(pwr_mode == PM_STOP));
endmodule

// File: rtl/supply_xing_irq.sv
module supply_xing_irq
  import scm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 6,
  parameter int BASE_SHIFT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_async,
  input  logic [1:0]       pwr_mode,
  input  logic             pclk_off,
  input  logic             reg_wr,
  input  logic [CTL_W-1:0] reg_wdata,
  output logic [CTL_W-1:0] reg_rdata,
  output logic             irq_o,
  output logic             wake_o
);
  logic lvl_s, rise, fall, samp_lvl, flag;
  cfg_t cfg;

  scm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_async), .q(lvl_s)
  );

  scm_sampler #(.CNT_W(DIV_W), .BASE_SHIFT(BASE_SHIFT)) u_samp (
    .clk(clk), .rst_n(rst_n), .en(cfg.det), .sel(cfg.sel), .lvl(lvl_s),
    .rise_o(rise), .fall_o(fall), .level_o(samp_lvl)
  );

  scm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .pwr_mode(pwr_mode), .pclk_off(pclk_off), .rise(rise), .fall(fall),
    .samp_lvl(samp_lvl), .cfg_o(cfg), .flag_o(flag), .irq_o(irq_o),
    .wake_o(wake_o)
  );

  assign reg_rdata = {flag, cfg};
endmodule

// File: tb/supply_xing_irq_tb.sv
module supply_xing_irq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_async = 1'b0;
  logic [1:0] pwr_mode = 2'b00;
  logic pclk_off = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_wdata = '0;
  logic [5:0] reg_rdata;
  logic irq_o, wake_o;
  logic [4:0] cfg_s = '0;
  int total = 0, bad = 0;
  bit wake_seen;

  always #2 clk = ~clk;

  supply_xing_irq u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_async(cmp_async), .pwr_mode(pwr_mode),
    .pclk_off(pclk_off), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] c, input logic keep);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = {keep, c}; cfg_s = c;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic measure(output int lat);
    lat = 0; wake_seen = 0;
    while (lat < 300) begin
      @(negedge clk); lat++;
      if (irq_o) begin wake_seen = wake_o; break; end
    end
  endtask

  task automatic quiet(input int n, output int ni, output int nw);
    ni = 0; nw = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_o) ni++;
      if (wake_o) nw++;
    end
  endtask

  task automatic t_reset();
    chk(reg_rdata == 6'd0, "R1 control word", reg_rdata, 0);
    chk(!irq_o && !wake_o, "R1 outputs idle", {irq_o, wake_o}, 0);
  endtask

  task automatic t_sweep(input logic [1:0] sel);
    int p, lat, mn, mx;
    p = 8 << sel; mn = 1000; mx = 0;
    wr({sel, 3'b011}, 1'b0);
    repeat (80) @(negedge clk);
    wr(cfg_s, 1'b0);
    for (int k = 0; k < p; k++) begin
      cmp_async = ~cmp_async;
      measure(lat);
      if (lat < mn) mn = lat;
      if (lat > mx) mx = lat;
      wr(cfg_s, 1'b0);
      repeat (k) @(negedge clk);
    end
    chk(mn == 4, "R2 min latency", mn, 4);
    chk(mx == p + 3, "R2 max latency", mx, p + 3);
  endtask

  task automatic t_directions();
    int lat;
    wr(5'b00011, 1'b0);
    cmp_async = 1'b0; repeat (30) @(negedge clk);
    wr(cfg_s, 1'b0);
    cmp_async = 1'b1; measure(lat);
    chk(lat < 300 && reg_rdata[5], "R3 rise sets flag", reg_rdata[5], 1);
    wr(cfg_s, 1'b0);
    chk(!reg_rdata[5], "R3 write 0 clears flag", reg_rdata[5], 0);
    cmp_async = 1'b0; measure(lat);
    chk(lat < 300 && reg_rdata[5], "R3 fall sets flag", reg_rdata[5], 1);
  endtask

  task automatic t_once();
    int ni, nw, lat;
    wr(cfg_s, 1'b1);
    chk(reg_rdata[5], "R3 write 1 keeps flag", reg_rdata[5], 1);
    cmp_async = 1'b1; quiet(40, ni, nw);
    chk(ni == 0, "R4 no request while flag set", ni, 0);
    wr(cfg_s, 1'b0);
    cmp_async = 1'b0; measure(lat);
    chk(lat < 300, "R4 request after clear", lat, 11);
    @(negedge clk);
    chk(!irq_o, "R4 single-cycle pulse", irq_o, 0);
  endtask

  task automatic t_enables();
    int ni, nw;
    wr(5'b00001, 1'b0);
    cmp_async = 1'b1; quiet(40, ni, nw);
    chk(ni == 0, "R5 interrupt enable off", ni, 0);
    chk(reg_rdata[5], "R5 flag still set", reg_rdata[5], 1);
    wr(5'b00010, 1'b0);
    cmp_async = 1'b0; quiet(40, ni, nw);
    chk(ni == 0 && !reg_rdata[5], "R5 detector off", {ni[0], reg_rdata[5]}, 0);
  endtask

  task automatic t_stop();
    int ni, nw, lat;
    wr(5'b00111, 1'b0);
    cmp_async = 1'b1; repeat (30) @(negedge clk);
    wr(cfg_s, 1'b0);
    cmp_async = 1'b0; measure(lat);
    pwr_mode = 2'b10; quiet(20, ni, nw);
    chk(ni == 0 && nw == 0, "R8 stop entry while low", ni + nw, 0);
    cmp_async = 1'b1; measure(lat);
    chk(lat < 300 && wake_seen, "R6 rise wakes despite flag", wake_seen, 1);
    cmp_async = 1'b0; quiet(40, ni, nw);
    chk(ni == 0 && nw == 0, "R6 fall silent in stop", ni + nw, 0);
    pwr_mode = 2'b00;
  endtask

  task automatic t_wait();
    int ni, nw, lat;
    pwr_mode = 2'b01; pclk_off = 1'b1;
    wr(cfg_s, 1'b0);
    cmp_async = 1'b1; measure(lat);
    chk(lat < 300 && !wake_seen, "R7 rise in clock-off wait", wake_seen, 0);
    wr(cfg_s, 1'b0);
    cmp_async = 1'b0; quiet(40, ni, nw);
    chk(ni == 0 && reg_rdata[5], "R7 fall: no request, flag set", ni, 0);
    pclk_off = 1'b0;
    wr(cfg_s, 1'b0);
    cmp_async = 1'b1; measure(lat);
    chk(lat < 300, "R7 wait with clocks acts as run", lat, 11);
    pwr_mode = 2'b00;
  endtask

  task automatic t_entry();
    repeat (30) @(negedge clk);
    wr(cfg_s, 1'b0);
    pwr_mode = 2'b10;
    @(negedge clk);
    chk(irq_o && wake_o, "R8 stop entry while high", {irq_o, wake_o}, 3);
    @(negedge clk);
    pwr_mode = 2'b00;
  endtask

  task automatic t_collide();
    int lat;
    wr(5'b00011, 1'b0);
    repeat (30) @(negedge clk);
    wr(cfg_s, 1'b0);
    cmp_async = ~cmp_async; measure(lat);
    cmp_async = ~cmp_async;
    repeat (7) @(negedge clk);
    reg_wr = 1'b1; reg_wdata = {1'b0, cfg_s};
    @(negedge clk);
    reg_wr = 1'b0;
    chk(reg_rdata[5], "R9 set wins over clear", reg_rdata[5], 1);
    chk(!irq_o, "R9 no request, flag never dropped", irq_o, 0);
    wr(cfg_s, 1'b0);
    chk(!reg_rdata[5], "R9 clear alone empties flag", reg_rdata[5], 0);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep(2'b00);
    t_sweep(2'b11);
    t_directions();
    t_once();
    t_enables();
    t_stop();
    t_wait();
    t_entry();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule